// File: doc/BRIEF.md
# Dual Window Voltage Monitor

The block watches two supply rails and checks each one against a voltage window. Every rail has two comparator bits. The low-trip bit is high while the rail sits above its minimum. The high-trip bit is high while the rail sits above its maximum. For each rail the block reports three things: a minimum-met status, a maximum-respected status, and a rail-good flag that means the rail is inside its window.

Each comparator bit first passes through a two-flop synchronizer. It then goes to a counter-based filter that works in clock cycles. A violation has to persist for `GLITCH_CYC` samples before the matching status drops. A rail below its minimum has to stay above it for the much longer `QUAL_CYC` samples before the minimum-met status is granted. The maximum-respected status comes back after `GLITCH_CYC` clean samples. The enable input parks both rails in their start-up state while it is low.

Top module: `dual_window_monitor`

## Requirements
- R1: While rst_ni is low and on release, every uv_ok_o bit is 0, every ov_ok_o bit is 1 and every pgood_o bit is 0.
- R2: With uv_ok_o[n] low, uv_ok_o[n] goes high on the (QUAL_CYC+2)-th rising edge after uv_above_i[n] goes high and stays high: two synchronizer edges, then QUAL_CYC consecutive high samples.
- R3: With uv_ok_o[n] high, uv_ok_o[n] and pgood_o[n] go low on the (GLITCH_CYC+2)-th rising edge after uv_above_i[n] goes low and stays low.
- R4: With ov_ok_o[n] high, ov_ok_o[n] and pgood_o[n] go low on the (GLITCH_CYC+2)-th rising edge after ov_above_i[n] goes high and stays high.
- R5: A low pulse on uv_above_i[n] or a high pulse on ov_above_i[n] that lasts fewer than GLITCH_CYC cycles changes no output.
- R6: After an overvoltage fault, ov_ok_o[n] goes back high on the (GLITCH_CYC+2)-th edge after ov_above_i[n] goes low and stays low. pgood_o[n] returns at the same edge if uv_ok_o[n] is still high, with no new qualification.
- R7: While uv_ok_o[n] is low, a single low sample of uv_above_i[n] restarts the qualification count from zero.
- R8: pgood_o[n] is high exactly when uv_ok_o[n] and ov_ok_o[n] are both high.
- R9: On every rising edge with en_i low, both rails return to the R1 values and the comparator inputs are ignored. After en_i returns high, uv_ok_o needs a full QUAL_CYC qualification.
- R10: The two rails are independent: stimulus on one rail's inputs never changes the other rail's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up stand-in) |
| en_i | input | 1 | Monitoring enable; low holds the start-up state |
| uv_above_i | input | NUM_RAILS | Per rail, 1 = rail above its low trip |
| ov_above_i | input | NUM_RAILS | Per rail, 1 = rail above its high trip |
| uv_ok_o | output | NUM_RAILS | Per rail, minimum qualified |
| ov_ok_o | output | NUM_RAILS | Per rail, maximum not exceeded |
| pgood_o | output | NUM_RAILS | Per rail, inside window |

## Verification
The filter assertions work on the synchronized comparator samples. They assume those samples reflect the input one synchronizer delay later, so each status flip can be tied to a sample that pointed the same way. The input pins are treated as asynchronous, but the bench changes them only on falling edges. Every pulse lasts a whole number of cycles, so the edge at which each status is expected to flip can be counted exactly. Enable is taken as a synchronous level: the bench drives it on falling edges and leaves the comparator inputs quiet for the synchronizer depth around re-enable.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wm_sync.sv
module wm_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [wm_pkg::SYNC_STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < wm_pkg::SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[wm_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/wm_qual_filter.sv
// Status flips after a run of consecutive samples pointing away from it.
module wm_qual_filter #(
  parameter int unsigned FAULT_CYC = 4,
  parameter int unsigned CLEAR_CYC = 4,
  parameter bit          OK_INIT   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic good_i,
  output logic ok_o
);
  localparam int unsigned MAX_CYC = wm_pkg::max_u(FAULT_CYC, CLEAR_CYC);
  localparam int unsigned CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CW-1:0] FAULT_LIM = CW'(FAULT_CYC - 1);
  localparam logic [CW-1:0] CLEAR_LIM = CW'(CLEAR_CYC - 1);

  logic          ok_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          toward;

  always_comb begin
    lim    = ok_q ? FAULT_LIM : CLEAR_LIM;
    toward = ok_q ? ~good_i : good_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= OK_INIT;
      cnt_q <= '0;
    end else if (clr_i) begin
      ok_q  <= OK_INIT;
      cnt_q <= '0;
    end else if (!toward) begin
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      ok_q  <= ~ok_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = ok_q;

  p_hold_while_good_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && good_i && !clr_i) |=> ok_q);

  p_clear_defaults_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ok_q == OK_INIT && cnt_q == '0));

  p_flip_follows_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ok_q != $past(ok_q)) && !$past(clr_i)) |-> ($past(ok_q) != $past(good_i)));
endmodule

// File: rtl/wm_rail.sv
module wm_rail #(
  parameter int unsigned GLITCH_CYC = 30,
  parameter int unsigned QUAL_CYC   = 160000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic uv_above_s_i,
  input  logic ov_above_s_i,
  output logic uv_ok_o,
  output logic ov_ok_o,
  output logic pgood_o
);
  logic uv_ok, ov_ok;

  wm_qual_filter #(.FAULT_CYC(GLITCH_CYC), .CLEAR_CYC(QUAL_CYC), .OK_INIT(1'b0)) i_uv_filt (
    .clk_i, .rst_ni, .clr_i(~en_i), .good_i(uv_above_s_i), .ok_o(uv_ok)
  );

  wm_qual_filter #(.FAULT_CYC(GLITCH_CYC), .CLEAR_CYC(GLITCH_CYC), .OK_INIT(1'b1)) i_ov_filt (
    .clk_i, .rst_ni, .clr_i(~en_i), .good_i(~ov_above_s_i), .ok_o(ov_ok)
  );

  assign uv_ok_o = uv_ok;
  assign ov_ok_o = ov_ok;
  assign pgood_o = uv_ok & ov_ok;

  p_pgood_rise_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> ($rose(uv_ok) || $rose(ov_ok)));

  p_uv_rise_needs_good_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uv_ok) |-> ($past(uv_above_s_i) && $past(en_i)));
endmodule

// File: rtl/dual_window_monitor.sv
module dual_window_monitor #(
  parameter int unsigned NUM_RAILS  = 2,
  parameter int unsigned GLITCH_CYC = 30,
  parameter int unsigned QUAL_CYC   = 160000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [NUM_RAILS-1:0] uv_above_i,
  input  logic [NUM_RAILS-1:0] ov_above_i,
  output logic [NUM_RAILS-1:0] uv_ok_o,
  output logic [NUM_RAILS-1:0] ov_ok_o,
  output logic [NUM_RAILS-1:0] pgood_o
);
  localparam int unsigned SW = 2 * NUM_RAILS;

  logic [SW-1:0] raw, synced;

  assign raw = {ov_above_i, uv_above_i};

  wm_sync #(.WIDTH(SW)) i_sync (.clk_i, .rst_ni, .d_i(raw), .q_o(synced));

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    wm_rail #(.GLITCH_CYC(GLITCH_CYC), .QUAL_CYC(QUAL_CYC)) i_rail (
      .clk_i,
      .rst_ni,
      .en_i,
      .uv_above_s_i(synced[r]),
      .ov_above_s_i(synced[NUM_RAILS + r]),
      .uv_ok_o(uv_ok_o[r]),
      .ov_ok_o(ov_ok_o[r]),
      .pgood_o(pgood_o[r])
    );
  end

  p_disabled_safe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (uv_ok_o == '0 && ov_ok_o == '1 && pgood_o == '0));
endmodule

// File: tb/test_dual_window_monitor.sv
module test_dual_window_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int GL = 4;
  localparam int QL = 20;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b1;
  logic [1:0] uv = 2'b00, ov = 2'b00;
  logic [1:0] uv_ok, ov_ok, pg;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_window_monitor #(.NUM_RAILS(2), .GLITCH_CYC(GL), .QUAL_CYC(QL)) i_dual_window_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .uv_above_i(uv), .ov_above_i(ov),
    .uv_ok_o(uv_ok), .ov_ok_o(ov_ok), .pgood_o(pg)
  );

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] e_uv, e_ov, e_pg);
    checks++;
    if (uv_ok !== e_uv || ov_ok !== e_ov || pg !== e_pg) begin
      errors++;
      $display("FAIL %s: uv/ov/pg actual %b/%b/%b expected %b/%b/%b",
               req, uv_ok, ov_ok, pg, e_uv, e_ov, e_pg);
    end
  endtask

  task automatic t_reset();
    cycles(3);
    check("R1 in reset", 2'b00, 2'b11, 2'b00);
    rst_ni = 1'b1;
    cycles(1);
    check("R1 after release", 2'b00, 2'b11, 2'b00);
  endtask

  task automatic t_qualify();
    uv = 2'b11;
    cycles(QL + 1);
    check("R2 not yet qualified", 2'b00, 2'b11, 2'b00);
    cycles(1);
    check("R2 qualified / R8 pgood", 2'b11, 2'b11, 2'b11);
  endtask

  task automatic t_glitch();
    uv = 2'b10;
    cycles(GL - 2);
    uv = 2'b11;
    cycles(GL + 4);
    check("R5 uv glitch ignored", 2'b11, 2'b11, 2'b11);
    ov = 2'b10;
    cycles(GL - 2);
    ov = 2'b00;
    cycles(GL + 4);
    check("R5 ov glitch ignored", 2'b11, 2'b11, 2'b11);
  endtask

  task automatic t_uv_fault();
    uv = 2'b10;
    cycles(GL + 1);
    check("R3 before filter time", 2'b11, 2'b11, 2'b11);
    cycles(1);
    check("R3 uv fault, R10 rail1 kept", 2'b10, 2'b11, 2'b10);
    uv = 2'b11;
    cycles(QL / 2);
    uv = 2'b10;
    cycles(0);
    uv = 2'b11;
    cycles(QL + 1);
    check("R7 count restarted", 2'b10, 2'b11, 2'b10);
    cycles(1);
    check("R7 requalified", 2'b11, 2'b11, 2'b11);
  endtask

  task automatic t_ov_fault();
    ov = 2'b01;
    cycles(GL + 1);
    check("R4 before filter time", 2'b11, 2'b11, 2'b11);
    cycles(1);
    check("R4 ov fault, R10 rail1 kept", 2'b11, 2'b10, 2'b10);
    ov = 2'b00;
    cycles(GL + 1);
    check("R6 still faulted", 2'b11, 2'b10, 2'b10);
    cycles(1);
    check("R6 ov recovered, pgood back", 2'b11, 2'b11, 2'b11);
  endtask

  task automatic t_enable();
    en = 1'b0;
    cycles(1);
    check("R9 disabled defaults", 2'b00, 2'b11, 2'b00);
    ov = 2'b11;
    cycles(GL + 5);
    check("R9 inputs ignored", 2'b00, 2'b11, 2'b00);
    ov = 2'b00;
    cycles(4);
    en = 1'b1;
    cycles(QL - 1);
    check("R9 full requalification", 2'b00, 2'b11, 2'b00);
    cycles(1);
    check("R9 qualified after enable", 2'b11, 2'b11, 2'b11);
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_glitch();
    t_uv_fault();
    t_ov_fault();
    t_enable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule